// File: doc/BRIEF.md
# Reciprocal square root estimator

This unit turns a single-precision floating-point operand into an estimate of its reciprocal square root that is accurate to 8 fraction bits. The estimate is not looked up in a table. It is found by a bit-exact incrementing search. A 9-bit index is built from the operand's fraction, and the exponent's parity decides how it is built. The index is then widened, and a counter steps upward from 512 until a multiply-compare against 2^28 fails. Each step of the search takes one clock. A caller raises `start_i` for one cycle with the operand and the mode enables, waits while `busy_o` is high, and collects the result and the flags when `done_o` pulses.

Subnormal operands are normalized one bit per cycle before the search begins. NaNs, zeros, negative operands and infinities do not use the search: they are resolved in the cycle after `start_i`. Two enables shape the float path. Flush-to-zero treats subnormal inputs as zero. Default-NaN mode replaces propagated NaNs with the canonical quiet NaN. A second mode treats the 32-bit operand as an unsigned fixed-point fraction and returns a 9-bit estimate in the top bits of the result.

Top module: `rsqrt_est`

## Requirements
- R1: For a positive normal float with biased exponent e and fraction f, the index is {1, f[22:15]} when e is even and {01, f[22:16]} when e is odd. An index i below 256 becomes 2i+1. Any other index has its LSB cleared and becomes 2(i+1). The counter b starts at 512 and increments while a·(b+1)² < 2^28. The estimate is (b+1)/2. The result is {0, (380−e)/2 in bits 30:23, the low 8 estimate bits in bits 22:15, zeros in bits 14:0}.
- R2: With flush-to-zero off, a subnormal is normalized first. Its fraction is shifted left and its exponent (starting at 0) is decremented until fraction bit 22 is 1. One more left shift drops that bit. R1 then applies with the signed exponent. Each normalizing shift takes one extra cycle, and the final drop takes one further cycle.
- R3: A NaN (exponent 0xFF, nonzero fraction) returns the operand with bit 22 set, or 0x7FC00000 when default-NaN mode is on. The invalid flag is raised only when bit 22 of the operand was 0 (signalling).
- R4: A zero returns an infinity of the same sign and raises divide-by-zero. With flush-to-zero on, a subnormal counts as a zero of its sign.
- R5: Any other negative operand, including −infinity, returns 0x7FC00000 and raises invalid.
- R6: +infinity returns +0 with no flags.
- R7: In fixed-point mode, an operand with bits 31:30 both zero returns 0xFFFFFFFF. Any other operand uses bits 31:23 as the index, with the R1 widening and search, and returns the 9-bit estimate in bits 31:23 with zeros below. Flags are never raised in this mode.
- R8: The special cases of R3 to R7 complete one cycle after `start_i` without raising `busy_o`. A search completes after (number of search increments + 2) cycles, plus the normalization cycles of R2.
- R9: `done_o` is high for exactly one cycle per operation. `busy_o` is low in that cycle. The result and the flags change only in that cycle and hold until the next completion.
- R10: `start_i` is ignored while `busy_o` is high. The running operation finishes with its own result.
- R11: After reset `busy_o`, `done_o`, the result and both flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation with the current operand and enables |
| fixed_i | input | 1 | 1 selects unsigned fixed-point mode, 0 selects single precision |
| op_i | input | 32 | Operand |
| ftz_i | input | 1 | Flush subnormal float inputs to zero |
| dnan_i | input | 1 | Return the default NaN for NaN inputs |
| busy_o | output | 1 | Normalization or search in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Estimate or special-case result |
| flag_inv_o | output | 1 | Invalid-operation flag of the last operation |
| flag_dz_o | output | 1 | Divide-by-zero flag of the last operation |

## Verification
The assertions watch the handshake on every cycle. They check that completion is a single-cycle pulse that never coincides with busy, that the unit only becomes busy through a start, and that the result holds between completions. They also check that a divide-by-zero result is always an infinity and that an invalid result is always a quiet NaN. Whether the estimate bits, the result exponent, the parity-dependent index and the exact latency are right can only be shown by the bench's scenarios. The bench compares each operation against a behavioural model that repeats the search with integers and predicts the completion cycle, including subnormals of several depths and a start raised mid-search.

// File: rtl/rsqe_pkg.sv
package rsqe_pkg;
    localparam int WORD_W     = 32;
    localparam int EXP_W      = 8;
    localparam int FRAC_W     = 23;
    localparam int IDX_W      = 9;
    localparam int A_W        = IDX_W + 1;
    localparam int B_W        = IDX_W + 2;
    localparam int SEXP_W     = EXP_W + 2;
    localparam int EST_W      = IDX_W;
    localparam int B_START    = 512;
    localparam int SEARCH_LOG = 28;
    localparam int EXP_OFS    = 380;
    localparam int SQ_W       = 2 * (B_W + 1);
    localparam int PROD_W     = SQ_W + A_W;
    localparam logic [WORD_W-1:0] DEF_NAN = 32'h7FC0_0000;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_NORM,
        ST_SEARCH
    } state_t;

    typedef struct packed {
        state_t              state;
        logic [A_W-1:0]      a;
        logic [B_W-1:0]      b;
        logic [SEXP_W-1:0]   e;
        logic [FRAC_W-1:0]   f;
        logic [EXP_W-1:0]    rexp;
        logic                fixed;
        logic [WORD_W-1:0]   result;
        logic                inv;
        logic                dz;
        logic                done;
    } regs_t;
endpackage

// File: rtl/rsqe_classify.sv
module rsqe_classify
    import rsqe_pkg::*;
(
    input  logic [WORD_W-1:0] op_i,
    input  logic              fixed_i,
    input  logic              ftz_i,
    input  logic              dnan_i,
    output logic              special_o,
    output logic              subn_o,
    output logic [WORD_W-1:0] res_o,
    output logic              inv_o,
    output logic              dz_o
);
    logic              sgn;
    logic [EXP_W-1:0]  ex;
    logic [FRAC_W-1:0] fr;
    logic              ex_max, ex_min, fr_nz;

    assign sgn    = op_i[WORD_W-1];
    assign ex     = op_i[WORD_W-2 -: EXP_W];
    assign fr     = op_i[FRAC_W-1:0];
    assign ex_max = &ex;
    assign ex_min = ~|ex;
    assign fr_nz  = |fr;

    always_comb begin
        special_o = 1'b1;
        subn_o    = 1'b0;
        res_o     = '0;
        inv_o     = 1'b0;
        dz_o      = 1'b0;
        if (fixed_i) begin
            special_o = ~|op_i[WORD_W-1 -: 2];
            res_o     = '1;
        end else if (ex_max && fr_nz) begin
            res_o = dnan_i ? DEF_NAN : (op_i | (WORD_W'(1) << (FRAC_W - 1)));
            inv_o = ~fr[FRAC_W-1];
        end else if (ex_min && (!fr_nz || ftz_i)) begin
            res_o = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            dz_o  = 1'b1;
        end else if (sgn) begin
            res_o = DEF_NAN;
            inv_o = 1'b1;
        end else if (ex_max) begin
            res_o = '0;
        end else begin
            special_o = 1'b0;
            subn_o    = ex_min;
        end
    end
endmodule

// File: rtl/rsqe_index.sv
module rsqe_index
    import rsqe_pkg::*;
(
    input  logic             fixed_i,
    input  logic             odd_i,
    input  logic [7:0]       frac_top_i,
    input  logic [IDX_W-1:0] fix_idx_i,
    output logic [A_W-1:0]   a_o
);
    logic [IDX_W-1:0] raw;
    logic [A_W-1:0]   evened;

    always_comb begin
        if (fixed_i)
            raw = fix_idx_i;
        else if (odd_i)
            raw = {2'b01, frac_top_i[7:1]};
        else
            raw = {1'b1, frac_top_i};
        evened = {1'b0, raw[IDX_W-1:1], 1'b0};
        if (raw[IDX_W-1])
            a_o = (evened + A_W'(1)) << 1;
        else
            a_o = {raw, 1'b1};
    end
endmodule

// File: rtl/rsqe_search_step.sv
module rsqe_search_step
    import rsqe_pkg::*;
(
    input  logic [A_W-1:0] a_i,
    input  logic [B_W-1:0] b_i,
    output logic           go_o
);
    logic [B_W:0]      bp1;
    logic [SQ_W-1:0]   sq;
    logic [PROD_W-1:0] prod;

    always_comb begin
        bp1  = {1'b0, b_i} + (B_W+1)'(1);
        sq   = SQ_W'(bp1) * SQ_W'(bp1);
        prod = PROD_W'(a_i) * PROD_W'(sq);
        go_o = prod < (PROD_W'(1) << SEARCH_LOG);
    end
endmodule

// File: rtl/rsqrt_est.sv
module rsqrt_est
    import rsqe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              fixed_i,
    input  logic [WORD_W-1:0] op_i,
    input  logic              ftz_i,
    input  logic              dnan_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [WORD_W-1:0] result_o,
    output logic              flag_inv_o,
    output logic              flag_dz_o
);
    regs_t q, d;

    logic              cls_special, cls_subn, cls_inv, cls_dz;
    logic [WORD_W-1:0] cls_res;
    logic              idx_fixed, idx_odd, search_go;
    logic [7:0]        idx_top;
    logic [A_W-1:0]    idx_a;
    logic [FRAC_W-1:0] f_dropped;
    logic [SEXP_W-1:0] e_sel, e_diff;
    logic [B_W-1:0]    b_inc;
    logic [EST_W-1:0]  est;

    rsqe_classify u_cls (
        .op_i      (op_i),
        .fixed_i   (fixed_i),
        .ftz_i     (ftz_i),
        .dnan_i    (dnan_i),
        .special_o (cls_special),
        .subn_o    (cls_subn),
        .res_o     (cls_res),
        .inv_o     (cls_inv),
        .dz_o      (cls_dz)
    );

    // Index source: the live operand at start, the normalized fraction after the last shift
    always_comb begin
        f_dropped = {q.f[FRAC_W-2:0], 1'b0};
        if (q.state == ST_NORM) begin
            idx_fixed = 1'b0;
            e_sel     = q.e;
            idx_top   = f_dropped[FRAC_W-1 -: 8];
        end else begin
            idx_fixed = fixed_i;
            e_sel     = SEXP_W'(op_i[WORD_W-2 -: EXP_W]);
            idx_top   = op_i[FRAC_W-1 -: 8];
        end
        idx_odd = e_sel[0];
        e_diff  = SEXP_W'(EXP_OFS) - e_sel;
    end

    rsqe_index u_idx (
        .fixed_i    (idx_fixed),
        .odd_i      (idx_odd),
        .frac_top_i (idx_top),
        .fix_idx_i  (op_i[WORD_W-1 -: IDX_W]),
        .a_o        (idx_a)
    );

    rsqe_search_step u_step (
        .a_i  (q.a),
        .b_i  (q.b),
        .go_o (search_go)
    );

    assign b_inc = q.b + B_W'(1);
    assign est   = b_inc[EST_W:1];

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    if (cls_special) begin
                        d.result = cls_res;
                        d.inv    = cls_inv;
                        d.dz     = cls_dz;
                        d.done   = 1'b1;
                    end else if (cls_subn) begin
                        d.state = ST_NORM;
                        d.e     = '0;
                        d.f     = op_i[FRAC_W-1:0];
                        d.fixed = 1'b0;
                    end else begin
                        d.state = ST_SEARCH;
                        d.a     = idx_a;
                        d.b     = B_W'(B_START);
                        d.rexp  = e_diff[EXP_W:1];
                        d.fixed = fixed_i;
                    end
                end
            end
            ST_NORM: begin
                if (q.f[FRAC_W-1]) begin
                    d.state = ST_SEARCH;
                    d.a     = idx_a;
                    d.b     = B_W'(B_START);
                    d.rexp  = e_diff[EXP_W:1];
                end else begin
                    d.f = {q.f[FRAC_W-2:0], 1'b0};
                    d.e = q.e - SEXP_W'(1);
                end
            end
            ST_SEARCH: begin
                if (search_go) begin
                    d.b = b_inc;
                end else begin
                    d.state = ST_IDLE;
                    d.done  = 1'b1;
                    d.inv   = 1'b0;
                    d.dz    = 1'b0;
                    if (q.fixed)
                        d.result = {est, {(WORD_W-EST_W){1'b0}}};
                    else
                        d.result = {1'b0, q.rexp, est[7:0], {(FRAC_W-8){1'b0}}};
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy_o     = (q.state != ST_IDLE);
    assign done_o     = q.done;
    assign result_o   = q.result;
    assign flag_inv_o = q.inv;
    assign flag_dz_o  = q.dz;
endmodule

// File: rtl/rsqrt_est_chk.sv
module rsqrt_est_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        busy_o,
    input logic        done_o,
    input logic [31:0] result_o,
    input logic        flag_inv_o,
    input logic        flag_dz_o
);
    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

    // R8
    busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> !busy_o);

    // R4
    dz_is_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_dz_o |-> (result_o[30:0] == 31'h7F80_0000));

    // R5
    inv_is_qnan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_inv_o |-> (result_o[30:22] == 9'h1FF));

    // R3
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag_inv_o && flag_dz_o));
endmodule

bind rsqrt_est rsqrt_est_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .result_o   (result_o),
    .flag_inv_o (flag_inv_o),
    .flag_dz_o  (flag_dz_o)
);

// File: tb/rsqrt_est_test.sv
module rsqrt_est_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        fixed_i = 1'b0;
    logic [31:0] op_i = '0;
    logic        ftz_i = 1'b0;
    logic        dnan_i = 1'b0;
    logic        busy_o, done_o, flag_inv_o, flag_dz_o;
    logic [31:0] result_o;

    int checks = 0;
    int failures = 0;
    int cycle_count = 0;

    always #4 clk = ~clk;

    rsqrt_est uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .fixed_i    (fixed_i),
        .op_i       (op_i),
        .ftz_i      (ftz_i),
        .dnan_i     (dnan_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .result_o   (result_o),
        .flag_inv_o (flag_inv_o),
        .flag_dz_o  (flag_dz_o)
    );

    always @(posedge clk) begin
        cycle_count <= cycle_count + 1;
        if (cycle_count > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog: run did not finish, actual cycles=%0d expected <150000", cycle_count);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            failures++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp_v);
        end
    endtask

    // Behavioural model of the requirements
    function automatic int search_count(input int a, output int est);
        longint b = 512;
        int n = 0;
        while (longint'(a) * (b + 1) * (b + 1) < (64'd1 << 28)) begin
            b++;
            n++;
        end
        est = int'((b + 1) / 2);
        return n;
    endfunction

    function automatic int widen(input int idx);
        if (idx < 256) return 2 * idx + 1;
        return 2 * ((idx - (idx % 2)) + 1);
    endfunction

    task automatic model(input bit fx, input logic [31:0] v, input bit ftz, input bit dn,
                         output logic [31:0] r, output bit inv, output bit dz, output int lat);
        int e, f, k, idx, est, n, rexp;
        bit s;
        inv = 0; dz = 0; lat = 1; r = 0;
        if (fx) begin
            if (v[31:30] == 2'b00) begin
                r = 32'hFFFF_FFFF;                             // R7
            end else begin
                n = search_count(widen(int'(v[31:23])), est);
                r = 32'(est) << 23;
                lat = n + 2;
            end
            return;
        end
        s = v[31]; e = int'(v[30:23]); f = int'(v[22:0]);
        if (e == 255 && f != 0) begin                          // R3
            r = dn ? 32'h7FC0_0000 : (v | 32'h0040_0000);
            inv = (v[22] == 1'b0);
        end else if (e == 0 && (f == 0 || ftz)) begin          // R4
            r = {s, 8'hFF, 23'h0}; dz = 1;
        end else if (s) begin                                   // R5
            r = 32'h7FC0_0000; inv = 1;
        end else if (e == 255) begin                            // R6
            r = 0;
        end else begin                                          // R1, R2
            k = 0;
            if (e == 0) begin
                while ((f & 32'h40_0000) == 0) begin
                    f = f << 1; e = e - 1; k++;
                end
                f = (f << 1) & 32'h7F_FFFF;
                k = k + 1;
            end
            if ((e & 1) != 0) idx = 128 + (f >> 16);
            else idx = 256 + (f >> 15);
            n = search_count(widen(idx), est);
            rexp = (380 - e) / 2;
            r = (32'(rexp) << 23) | (32'(est & 255) << 15);
            lat = k + n + 2;
        end
    endtask

    task automatic run_op(input string req, input bit fx, input logic [31:0] v,
                          input bit ftz, input bit dn, input bit poke);
        logic [31:0] er;
        bit ei, ed, busy_bad;
        int lat, cyc;
        model(fx, v, ftz, dn, er, ei, ed, lat);
        @(negedge clk);
        fixed_i = fx; op_i = v; ftz_i = ftz; dnan_i = dn; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 1; busy_bad = 0;
        while (!done_o && cyc < 3000) begin
            if (busy_o !== 1'b1) busy_bad = 1;
            if (poke && cyc == 2) begin
                start_i = 1'b1; op_i = 32'h7F80_0000; fixed_i = 1'b0;  // R10
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start_i = 1'b0;
        check({req, " R8 latency"}, 32'(cyc), 32'(lat));
        check({req, " result"}, result_o, er);
        check({req, " R3/R5 invalid flag"}, {31'b0, flag_inv_o}, {31'b0, ei});
        check({req, " R4 dz flag"}, {31'b0, flag_dz_o}, {31'b0, ed});
        check({req, " R9 busy low at done / high before"}, {30'b0, busy_o, busy_bad}, 32'b0);
        @(negedge clk);
        check({req, " R9 single done pulse"}, {31'b0, done_o}, 32'b0);
        check({req, " R9 result held"}, result_o, er);
    endtask

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 busy", {31'b0, busy_o}, 0);
        check("R11 done", {31'b0, done_o}, 0);
        check("R11 result", result_o, 0);
        check("R11 flags", {30'b0, flag_inv_o, flag_dz_o}, 0);
        rst_n = 1'b1;

        run_op("R1 one", 0, 32'h3F80_0000, 0, 0, 0);
        run_op("R1 four", 0, 32'h4080_0000, 0, 0, 0);
        run_op("R1 two even exp", 0, 32'h4000_0000, 0, 0, 0);
        run_op("R1 max normal", 0, 32'h7F7F_FFFF, 0, 0, 0);
        run_op("R1 min normal", 0, 32'h0080_0000, 0, 0, 0);
        run_op("R1 mid", 0, 32'h42C8_1234, 0, 0, 0);
        run_op("R2 smallest subnormal", 0, 32'h0000_0001, 0, 0, 0);
        run_op("R2 top subnormal", 0, 32'h0040_0000, 0, 0, 0);
        run_op("R2 subnormal", 0, 32'h0001_2345, 0, 0, 0);
        run_op("R4 ftz subnormal", 0, 32'h0001_2345, 1, 0, 0);
        run_op("R4 ftz neg subnormal", 0, 32'h8001_2345, 1, 0, 0);
        run_op("R3 quiet nan", 0, 32'h7FC1_2345, 0, 0, 0);
        run_op("R3 signalling nan", 0, 32'h7F81_2345, 0, 0, 0);
        run_op("R3 signalling nan default", 0, 32'hFF81_2345, 0, 1, 0);
        run_op("R3 negative quiet nan", 0, 32'hFFC0_0001, 0, 0, 0);
        run_op("R4 plus zero", 0, 32'h0000_0000, 0, 0, 0);
        run_op("R4 minus zero", 0, 32'h8000_0000, 0, 0, 0);
        run_op("R5 minus one", 0, 32'hBF80_0000, 0, 0, 0);
        run_op("R5 minus inf", 0, 32'hFF80_0000, 0, 0, 0);
        run_op("R6 plus inf", 0, 32'h7F80_0000, 0, 0, 0);
        run_op("R7 fixed small", 1, 32'h3FFF_FFFF, 0, 0, 0);
        run_op("R7 fixed quarter", 1, 32'h4000_0000, 0, 0, 0);
        run_op("R7 fixed half", 1, 32'h8000_0000, 0, 0, 0);
        run_op("R7 fixed max", 1, 32'hFFFF_FFFF, 0, 0, 0);
        run_op("R7 fixed ignores float enables", 1, 32'h7FC0_0000, 1, 1, 0);
        run_op("R10 start while busy", 0, 32'h3F80_0000, 0, 0, 1);
        run_op("R10 start while normalizing", 0, 32'h0000_0003, 0, 0, 1);

        lfsr = 32'hACE1_2468;
        for (int i = 0; i < 40; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            run_op("R1/R7 sweep", lfsr[5], lfsr, lfsr[9], lfsr[13], 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule